// File: doc/BRIEF.md
# Self-Programming Command Arming Register

This block is the byte-wide control and status register that a bootloader uses to start self-programming operations. Software writes a command code into the low five bits. A valid code arms the command for a short window of clock cycles. If a store-program strobe arrives while the window is open, the block sends a one-cycle command pulse to the flash or lock-storage side. If no strobe arrives, the arming bits clear by themselves when the window closes, so no stale command is left behind.

The register can be reached in two ways. In data-space addressing it sits at 0x57. In the direct I/O space it sits at 0x37, which is the data offset less 0x20. The upper three bits are plain read/write control and status bits. While a lock-set command is armed, an early load-program strobe is sent to the lock bits or to the fuse bits instead of program memory. The low bit of the Z pointer picks which of the two.

Top module: `selfprog_ctrl`

## Requirements
- R1: After reset the register reads 0x00, and none of the command pulses or load-redirect outputs is active.
- R2: The register is selected when `bus_io`=0 and `bus_addr`=0x57, or when `bus_io`=1 and `bus_addr`=0x37. With any other address, a write has no effect and a read returns 0x00. Reads are combinational.
- R3: Bits 7:5 (7 = interrupt enable, 6 = read-while-write busy, 5 = signature read) take the written value on every selected write, whatever the low five bits hold.
- R4: A write to bits 4:0 takes effect only for the values 00000, 00001, 00011, 00101, 01001 and 10001. Any other value leaves bits 4:0 as they were.
- R5: Bits 4:0 mean: bit 0 = enable, bit 1 = page erase, bit 2 = page write, bit 3 = lock-bit set, bit 4 = read-while-write section read enable. Each command is the enable bit plus at most one of the other bits. A store-program strobe that is accepted produces a one-cycle pulse in the next cycle on the matching output: 00001 → `fill_pulse`, 00011 → `erase_pulse`, 00101 → `pgwr_pulse`, 10001 → `rwwen_pulse`. The same accept clears bits 4:0.
- R6: The arming write happens at clock edge E0. A store-program strobe is accepted at any of the edges E1 to E4. If no strobe comes, bits 4:0 still hold the command after E3 and read 00000 after E4. A strobe at E5 produces no pulse.
- R7: An accepted strobe with 01001 armed pulses `lock_wr_pulse` with `lock_wdata` equal to the `r0_data` byte at the strobe. Bits 4:0 then keep reading 01001, and later strobes are not accepted, until a `lock_done` pulse clears them to 00000.
- R8: While 01001 is armed and no lock write is pending, a `lpm_strobe` in one of the first three cycles after the arming edge (E0 to E1, E1 to E2, E2 to E3) raises `lpm_lock_sel` if `z_lsb`=0, or `lpm_fuse_sel` if `z_lsb`=1. Both outputs stay low in the fourth cycle and whenever any other command is armed.
- R9: Every valid arming write restarts the window, and a write of 00000 disarms at once.
- R10: If a valid arming write and a store-program strobe fall in the same cycle, the write takes effect and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register bus address |
| bus_io | input | 1 | 1 = direct I/O addressing, 0 = data-space addressing |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, 0 when not selected |
| spm_strobe | input | 1 | Store-program instruction strobe |
| lpm_strobe | input | 1 | Load-program instruction strobe |
| r0_data | input | 8 | Data byte from working register R0 |
| z_lsb | input | 1 | Bit 0 of the Z pointer |
| lock_done | input | 1 | One-cycle completion pulse from lock storage |
| fill_pulse | output | 1 | Page buffer fill command pulse |
| erase_pulse | output | 1 | Page erase command pulse |
| pgwr_pulse | output | 1 | Page write command pulse |
| rwwen_pulse | output | 1 | Read-while-write section re-enable pulse |
| lock_wr_pulse | output | 1 | Lock bit write request pulse |
| lock_wdata | output | 8 | Lock bit value captured from R0 |
| lpm_lock_sel | output | 1 | Load-program read redirected to the lock bits |
| lpm_fuse_sel | output | 1 | Load-program read redirected to the fuse bits |

## Verification
The bench tries all 32 low-bit write values from the idle state, which shows the six accepted codes apart from the 26 that are rejected. It then arms each command and sends a strobe after 0 to 4 idle cycles, which shows acceptance at the last open edge apart from expiry one edge later. The lock-set command is driven to its pending state, including a strobe sent while the lock write is pending, and a lock-done pulse then releases it. The load-program strobe is swept across four cycles with both values of the Z-pointer bit. Re-arming just before expiry, and a write landing in the same cycle as a strobe, show that the window restarts and that the write takes priority.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;

    localparam int LOW_W = 5;
    localparam int HI_W  = 3;
    localparam int NUM_OPS = 5;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_FILL  = 3'd1,
        OP_ERASE = 3'd2,
        OP_PGWR  = 3'd3,
        OP_LOCK  = 3'd4,
        OP_RWWEN = 3'd5
    } spm_op_e;

    typedef struct packed {
        logic irq_en;
        logic rww_busy;
        logic sig_read;
    } csr_hi_t;

    typedef struct packed {
        logic    valid;
        spm_op_e op;
    } arm_req_t;

    // Only enable-plus-at-most-one-command patterns are legal; 00000 disarms.
    function automatic arm_req_t decode_low(input logic [LOW_W-1:0] v);
        arm_req_t r;
        r.valid = 1'b1;
        r.op    = OP_IDLE;
        case (v)
            5'b00000: r.op = OP_IDLE;
            5'b00001: r.op = OP_FILL;
            5'b00011: r.op = OP_ERASE;
            5'b00101: r.op = OP_PGWR;
            5'b01001: r.op = OP_LOCK;
            5'b10001: r.op = OP_RWWEN;
            default:  r.valid = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic [LOW_W-1:0] encode_low(input spm_op_e op);
        logic [LOW_W-1:0] v;
        case (op)
            OP_FILL:  v = 5'b00001;
            OP_ERASE: v = 5'b00011;
            OP_PGWR:  v = 5'b00101;
            OP_LOCK:  v = 5'b01001;
            OP_RWWEN: v = 5'b10001;
            default:  v = 5'b00000;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/selfprog_bus_dec.sv
module selfprog_bus_dec
    import selfprog_pkg::*;
#(
    parameter logic [7:0] DATA_ADDR = 8'h57,
    parameter logic [7:0] IO_SHIFT  = 8'h20
) (
    input  logic       [7:0] bus_addr,
    input  logic             bus_io,
    input  logic             bus_we,
    input  logic       [7:0] bus_wdata,
    output logic             hit,
    output logic             hi_we,
    output csr_hi_t          hi_wdata,
    output logic             arm_we,
    output spm_op_e          arm_op
);

    localparam logic [7:0] IO_ADDR = DATA_ADDR - IO_SHIFT;

    arm_req_t req;

    always_comb begin
        hit      = bus_io ? (bus_addr == IO_ADDR) : (bus_addr == DATA_ADDR);
        hi_we    = hit && bus_we;
        hi_wdata = csr_hi_t'(bus_wdata[7:LOW_W]);
        req      = decode_low(bus_wdata[LOW_W-1:0]);
        arm_we   = hit && bus_we && req.valid;
        arm_op   = req.op;
    end

endmodule

// File: rtl/selfprog_window.sv
module selfprog_window #(
    parameter int SPM_WIN = 4,
    parameter int LPM_WIN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic spm_open,
    output logic lpm_open,
    output logic expire
);

    localparam int CW = $clog2(SPM_WIN + 1);
    localparam logic [CW-1:0] LAST    = CW'(SPM_WIN - 1);
    localparam logic [CW-1:0] LPM_LIM = CW'(LPM_WIN);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        spm_open = run && (cnt_q <= LAST);
        lpm_open = run && (cnt_q < LPM_LIM);
        expire   = run && (cnt_q == LAST);
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST); // R6

endmodule

// File: rtl/selfprog_issue.sv
module selfprog_issue
    import selfprog_pkg::*;
#(
    parameter int OPS = NUM_OPS
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           fire,
    input  spm_op_e        op,
    input  logic     [7:0] r0_data,
    output logic [OPS-1:0] pulse_q,
    output logic     [7:0] lock_data_q
);

    for (genvar i = 0; i < OPS; i++) begin : g_pulse
        localparam spm_op_e THIS_OP = spm_op_e'(3'(i + 1));
        always_ff @(posedge clk) begin
            if (rst) pulse_q[i] <= 1'b0;
            else     pulse_q[i] <= fire && (op == THIS_OP);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                          lock_data_q <= '0;
        else if (fire && op == OP_LOCK)   lock_data_q <= r0_data;
    end

    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pulse_q)); // R5

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (|pulse_q) |=> !(|pulse_q)); // R5

endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl
    import selfprog_pkg::*;
#(
    parameter int         SPM_WIN   = 4,
    parameter int         LPM_WIN   = 3,
    parameter logic [7:0] DATA_ADDR = 8'h57,
    parameter logic [7:0] IO_SHIFT  = 8'h20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] bus_addr,
    input  logic       bus_io,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       spm_strobe,
    input  logic       lpm_strobe,
    input  logic [7:0] r0_data,
    input  logic       z_lsb,
    input  logic       lock_done,
    output logic       fill_pulse,
    output logic       erase_pulse,
    output logic       pgwr_pulse,
    output logic       rwwen_pulse,
    output logic       lock_wr_pulse,
    output logic [7:0] lock_wdata,
    output logic       lpm_lock_sel,
    output logic       lpm_fuse_sel
);

    logic    hit, hi_we, arm_we;
    csr_hi_t hi_wdata;
    spm_op_e arm_op;

    csr_hi_t hi_q;
    spm_op_e op_q, op_d;
    logic    busy_q, busy_d;

    logic armed, run, fire;
    logic spm_open, lpm_open, expire;
    logic [NUM_OPS-1:0] pulses;

    selfprog_bus_dec #(.DATA_ADDR(DATA_ADDR), .IO_SHIFT(IO_SHIFT)) u_dec (
        .bus_addr (bus_addr),
        .bus_io   (bus_io),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .hit      (hit),
        .hi_we    (hi_we),
        .hi_wdata (hi_wdata),
        .arm_we   (arm_we),
        .arm_op   (arm_op)
    );

    selfprog_window #(.SPM_WIN(SPM_WIN), .LPM_WIN(LPM_WIN)) u_win (
        .clk     (clk),
        .rst     (rst),
        .restart (arm_we),
        .run     (run),
        .spm_open(spm_open),
        .lpm_open(lpm_open),
        .expire  (expire)
    );

    selfprog_issue #(.OPS(NUM_OPS)) u_issue (
        .clk        (clk),
        .rst        (rst),
        .fire       (fire),
        .op         (op_q),
        .r0_data    (r0_data),
        .pulse_q    (pulses),
        .lock_data_q(lock_wdata)
    );

    always_comb begin
        armed = (op_q != OP_IDLE);
        run   = armed && !busy_q;
        fire  = run && spm_strobe && spm_open && !arm_we;
    end

    // Priority: bus arming write, then lock completion, then strobe, then expiry.
    always_comb begin
        op_d   = op_q;
        busy_d = busy_q;
        if (arm_we) begin
            op_d   = arm_op;
            busy_d = 1'b0;
        end else if (busy_q) begin
            if (lock_done) begin
                op_d   = OP_IDLE;
                busy_d = 1'b0;
            end
        end else if (fire) begin
            if (op_q == OP_LOCK) busy_d = 1'b1;
            else                 op_d   = OP_IDLE;
        end else if (expire) begin
            op_d = OP_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            op_q   <= OP_IDLE;
            busy_q <= 1'b0;
        end else begin
            if (hi_we) hi_q <= hi_wdata;
            op_q   <= op_d;
            busy_q <= busy_d;
        end
    end

    always_comb begin
        bus_rdata     = hit ? {hi_q, encode_low(op_q)} : 8'h00;
        fill_pulse    = pulses[int'(OP_FILL)  - 1];
        erase_pulse   = pulses[int'(OP_ERASE) - 1];
        pgwr_pulse    = pulses[int'(OP_PGWR)  - 1];
        lock_wr_pulse = pulses[int'(OP_LOCK)  - 1];
        rwwen_pulse   = pulses[int'(OP_RWWEN) - 1];
        lpm_lock_sel  = lpm_strobe && lpm_open && (op_q == OP_LOCK) && !z_lsb;
        lpm_fuse_sel  = lpm_strobe && lpm_open && (op_q == OP_LOCK) &&  z_lsb;
    end

    AST_REJECT_KEEPS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (hi_we && !arm_we && op_q == OP_IDLE && !busy_q) |=> (op_q == OP_IDLE)); // R4

    AST_EXPIRE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (expire && !spm_strobe && !arm_we) |=> (op_q == OP_IDLE)); // R6

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !lock_done && !arm_we) |=> (busy_q && op_q == OP_LOCK)); // R7

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        arm_we |=> (pulses == '0)); // R10

endmodule

// File: tb/selfprog_ctrl_bench.sv
module selfprog_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic       bus_io = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       spm_strobe = 1'b0;
    logic       lpm_strobe = 1'b0;
    logic [7:0] r0_data = '0;
    logic       z_lsb = 1'b0;
    logic       lock_done = 1'b0;
    logic       fill_pulse, erase_pulse, pgwr_pulse, rwwen_pulse, lock_wr_pulse;
    logic [7:0] lock_wdata;
    logic       lpm_lock_sel, lpm_fuse_sel;

    always #5 clk = ~clk;

    selfprog_ctrl u_selfprog_ctrl (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_io(bus_io), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spm_strobe(spm_strobe), .lpm_strobe(lpm_strobe),
        .r0_data(r0_data), .z_lsb(z_lsb), .lock_done(lock_done),
        .fill_pulse(fill_pulse), .erase_pulse(erase_pulse),
        .pgwr_pulse(pgwr_pulse), .rwwen_pulse(rwwen_pulse),
        .lock_wr_pulse(lock_wr_pulse), .lock_wdata(lock_wdata),
        .lpm_lock_sel(lpm_lock_sel), .lpm_fuse_sel(lpm_fuse_sel)
    );

    // Pulse kinds used by the scoreboard: 1 fill, 2 erase, 3 page write, 4 lock, 5 rww enable.
    typedef struct { int kind; logic [7:0] data; } exp_t;
    exp_t sbq[$];

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    int  n_hi, seen_kind;
    exp_t front;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: pops an expected item for every observed pulse.
    always @(negedge clk) begin
        if (!rst) begin
            n_hi = int'(fill_pulse) + int'(erase_pulse) + int'(pgwr_pulse)
                 + int'(lock_wr_pulse) + int'(rwwen_pulse);
            if (n_hi > 0) begin
                seen_kind = fill_pulse ? 1 : erase_pulse ? 2 : pgwr_pulse ? 3 :
                            lock_wr_pulse ? 4 : 5;
                if (n_hi > 1) begin
                    chk(0, "R5 multiple pulses", n_hi, 1);
                end else if (sbq.size() == 0) begin
                    chk(0, "R5 unexpected pulse kind", seen_kind, 0);
                end else begin
                    front = sbq.pop_front();
                    chk(seen_kind == front.kind, "R5 pulse kind", seen_kind, front.kind);
                    if (front.kind == 4)
                        chk(lock_wdata == front.data, "R7 lock data", lock_wdata, front.data);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input bit io, input logic [7:0] d);
        bus_addr = a; bus_io = io; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 8'h00; bus_io = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input bit io, input logic [7:0] exp, input string req);
        bus_addr = a; bus_io = io;
        #1;
        chk(bus_rdata == exp, req, bus_rdata, exp);
        bus_addr = 8'h00; bus_io = 1'b0;
    endtask

    task automatic spm(input logic [7:0] r0, input int kind);
        exp_t e;
        if (kind != 0) begin
            e.kind = kind; e.data = r0;
            sbq.push_back(e);
        end
        spm_strobe = 1'b1; r0_data = r0;
        @(negedge clk);
        spm_strobe = 1'b0;
    endtask

    task automatic quiet_chk(input string req);
        logic [4:0] p;
        p = {fill_pulse, erase_pulse, pgwr_pulse, lock_wr_pulse, rwwen_pulse};
        chk(p == 5'b0, req, p, 0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [4:0] legal(input logic [4:0] v);
        case (v)
            5'b00001, 5'b00011, 5'b00101, 5'b01001, 5'b10001: return v;
            default: return 5'b00000;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1
        rd_chk(8'h57, 0, 8'h00, "R1 reset value");
        quiet_chk("R1 no pulse after reset");
        chk({lpm_lock_sel, lpm_fuse_sel} == 2'b00, "R1 redirect idle", {lpm_lock_sel, lpm_fuse_sel}, 0);

        // R2
        wr(8'h37, 1, 8'hE0);
        rd_chk(8'h57, 0, 8'hE0, "R2 io write seen in data space");
        rd_chk(8'h37, 1, 8'hE0, "R2 io read");
        rd_chk(8'h57, 1, 8'h00, "R2 wrong space read");
        wr(8'h56, 0, 8'h01);
        rd_chk(8'h57, 0, 8'hE0, "R2 other address ignored");
        wr(8'h57, 0, 8'h00);

        // R3
        wr(8'h57, 0, 8'hBF);
        rd_chk(8'h57, 0, 8'hA0, "R3 upper bits with rejected low");
        wr(8'h57, 0, 8'h40);
        rd_chk(8'h57, 0, 8'h40, "R3 upper bits rewritten");
        wr(8'h57, 0, 8'h00);

        // R4: full sweep from idle
        for (int v = 0; v < 32; v++) begin
            wr(8'h57, 0, 8'(v));
            rd_chk(8'h57, 0, {3'b000, legal(5'(v))}, "R4 low pattern filter");
            wr(8'h57, 0, 8'h00);
        end
        wr(8'h57, 0, 8'h05);
        wr(8'h57, 0, 8'h07);
        rd_chk(8'h57, 0, 8'h05, "R4 rejected write keeps armed command");
        wr(8'h57, 0, 8'h00);

        // R5: each command
        wr(8'h57, 0, 8'h01); spm(8'h00, 1); rd_chk(8'h57, 0, 8'h00, "R5 fill clears");
        wr(8'h57, 0, 8'h03); spm(8'h00, 2); rd_chk(8'h57, 0, 8'h00, "R5 erase clears");
        wr(8'h57, 0, 8'h05); spm(8'h00, 3); rd_chk(8'h57, 0, 8'h00, "R5 page write clears");
        wr(8'h57, 0, 8'h11); spm(8'h00, 5); rd_chk(8'h57, 0, 8'h00, "R5 rww enable clears");

        // R6: window sweep
        for (int k = 0; k <= 4; k++) begin
            wr(8'h57, 0, 8'h03);
            idle(k);
            spm(8'h00, (k <= 3) ? 2 : 0);
            if (k == 4) quiet_chk("R6 strobe after window");
        end
        wr(8'h57, 0, 8'h05);
        idle(3);
        rd_chk(8'h57, 0, 8'h05, "R6 still armed at last open edge");
        idle(1);
        rd_chk(8'h57, 0, 8'h00, "R6 expired");

        // R7: lock set
        wr(8'h57, 0, 8'h09);
        spm(8'h5A, 4);
        idle(6);
        spm(8'h11, 0);
        quiet_chk("R7 strobe while lock pending");
        rd_chk(8'h57, 0, 8'h09, "R7 lock pending holds bits");
        lock_done = 1'b1;
        @(negedge clk);
        lock_done = 1'b0;
        rd_chk(8'h57, 0, 8'h00, "R7 lock done clears");

        // R8: load redirect
        for (int z = 0; z < 2; z++) begin
            wr(8'h57, 0, 8'h09);
            for (int k = 0; k < 4; k++) begin
                lpm_strobe = 1'b1; z_lsb = z[0];
                #1;
                chk(lpm_lock_sel == (k < 3 && z == 0), "R8 lock redirect", lpm_lock_sel, (k < 3 && z == 0));
                chk(lpm_fuse_sel == (k < 3 && z == 1), "R8 fuse redirect", lpm_fuse_sel, (k < 3 && z == 1));
                @(negedge clk);
            end
            lpm_strobe = 1'b0;
        end
        wr(8'h57, 0, 8'h05);
        lpm_strobe = 1'b1; z_lsb = 1'b0;
        #1;
        chk({lpm_lock_sel, lpm_fuse_sel} == 2'b00, "R8 no redirect for other command",
            {lpm_lock_sel, lpm_fuse_sel}, 0);
        lpm_strobe = 1'b0;
        wr(8'h57, 0, 8'h00);

        // R9: restart and disarm
        wr(8'h57, 0, 8'h03);
        idle(3);
        wr(8'h57, 0, 8'h03);
        idle(3);
        spm(8'h00, 2);
        wr(8'h57, 0, 8'h05);
        wr(8'h57, 0, 8'h00);
        spm(8'h00, 0);
        quiet_chk("R9 disarmed strobe");
        rd_chk(8'h57, 0, 8'h00, "R9 disarm reads zero");

        // R10: write and strobe in one cycle
        wr(8'h57, 0, 8'h03);
        bus_addr = 8'h57; bus_io = 1'b0; bus_wdata = 8'h05; bus_we = 1'b1; spm_strobe = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; spm_strobe = 1'b0; bus_addr = 8'h00;
        quiet_chk("R10 write wins over strobe");
        rd_chk(8'h57, 0, 8'h05, "R10 new command armed");
        wr(8'h57, 0, 8'h00);

        idle(2);
        chk(sbq.size() == 0, "R5 expected pulses missing", sbq.size(), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule